// File: doc/BRIEF.md
# ADC Result Qualify and Hold Stage

This block takes the raw conversion code that an analog-to-digital converter core presents with a one-cycle valid strobe. It trims the code to the active resolution and, when threshold filtering is switched on, keeps only codes that lie strictly above or strictly below a programmed limit. A code that qualifies is stored right-justified in a 16-bit result register, and the completion flag is raised. The interrupt request follows the completion flag when interrupts are enabled.

A code that fails the threshold test is dropped without trace: neither the result nor the completion flag moves. A system can therefore sleep and be woken only when the input crosses the limit. Software consumes a result by pulsing the read strobe, which clears the completion flag. A qualifying code that arrives while an earlier result is still unread overwrites it and raises a sticky overrun flag.

Top module: `adc_result_stage`

## Requirements
- R1: After reset, result is 0 and done, irq and overrun are all 0.
- R2: With res_sel = 2'b00 (8-bit), a committed code stores raw_code[7:0] in result[7:0], and result[15:8] is 0.
- R3: With res_sel = 2'b01, result holds raw_code[9:0] and the upper bits are 0. With res_sel = 2'b10, or with 2'b11 (taken as 12-bit), result holds raw_code[11:0] and result[15:12] is 0.
- R4: With cmp_en = 0, every cycle with raw_valid = 1 commits the trimmed code, visible on result and done after the next rising clock edge.
- R5: With cmp_en = 1 and cmp_above = 1, a code commits only if the trimmed code is strictly greater than the trimmed threshold. An equal code does not commit.
- R6: With cmp_en = 1 and cmp_above = 0, a code commits only if the trimmed code is strictly less than the trimmed threshold. An equal code does not commit.
- R7: A code that fails the compare leaves result, done and overrun unchanged.
- R8: A commit sets done. A cycle with result_rd = 1 and no commit clears done at the next edge. A commit in the same cycle as result_rd leaves done set.
- R9: irq is a registered copy of done gated by irq_en: after each edge, irq = done AND the irq_en value sampled at that edge.
- R10: A commit while done = 1 and result_rd = 0 sets overrun. overrun then stays set until a cycle with result_rd = 1 that does not itself set it.
- R11: The threshold cmp_value is trimmed to the active resolution before the compare. The compare is unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_code | input | 12 | Raw conversion code from the converter core |
| raw_valid | input | 1 | One-cycle strobe marking raw_code valid |
| res_sel | input | 2 | Resolution: 00 = 8-bit, 01 = 10-bit, 10/11 = 12-bit |
| cmp_en | input | 1 | Enable threshold filtering |
| cmp_above | input | 1 | 1 = keep codes above the threshold, 0 = keep codes below it |
| cmp_value | input | 12 | Threshold value |
| irq_en | input | 1 | Interrupt enable |
| result_rd | input | 1 | Read strobe; clears done |
| result | output | 16 | Right-justified stored result |
| done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky flag: an unread result was overwritten |

## Verification
The assertions assume that res_sel, cmp_en, cmp_above and cmp_value are stable in any cycle where raw_valid is high. They also assume that the 12-bit code width is narrower than the 16-bit result register. The stimulus changes configuration only on falling edges, and in directed phases only while raw_valid is low. In the randomized phase every input is redrawn each cycle, but all inputs are still driven at the falling edge, so each rising edge sees one coherent set. The randomized phase mixes commits, threshold rejections and reads in the same cycle. This exercises the priority between a new commit and a read, and the overrun set and clear rules.

// File: rtl/adc_rs_pkg.sv
package adc_rs_pkg;
  typedef enum logic [1:0] {
    RES_LOW  = 2'b00,
    RES_MID  = 2'b01,
    RES_FULL = 2'b10,
    RES_ALT  = 2'b11
  } res_mode_t;
endpackage

// File: rtl/rs_trunc.sv
module rs_trunc #(
  parameter int RAW_W = 12
) (
  input  logic [1:0]       mode,
  input  logic [RAW_W-1:0] code_in,
  output logic [RAW_W-1:0] code_out
);
  import adc_rs_pkg::*;
  localparam int LOW_W = RAW_W - 4;
  localparam int MID_W = RAW_W - 2;
  localparam logic [RAW_W-1:0] LOW_MASK = RAW_W'((1 << LOW_W) - 1);
  localparam logic [RAW_W-1:0] MID_MASK = RAW_W'((1 << MID_W) - 1);

  always_comb begin
    unique case (res_mode_t'(mode))
      RES_LOW: code_out = code_in & LOW_MASK;
      RES_MID: code_out = code_in & MID_MASK;
      default: code_out = code_in;
    endcase
  end
endmodule

// File: rtl/rs_qualify.sv
module rs_qualify #(
  parameter int RAW_W = 12
) (
  input  logic             valid,
  input  logic             cmp_en,
  input  logic             above,
  input  logic [RAW_W-1:0] code,
  input  logic [RAW_W-1:0] thr,
  output logic             commit
);
  logic gt, lt;

  always_comb begin
    gt = code > thr;
    lt = code < thr;
    commit = valid & (~cmp_en | (above ? gt : lt));
  end
endmodule

// File: rtl/rs_hold.sv
module rs_hold #(
  parameter int RAW_W = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [RAW_W-1:0] code,
  input  logic             rd,
  input  logic             irq_en,
  output logic [OUT_W-1:0] result,
  output logic             done,
  output logic             irq,
  output logic             overrun
);
  logic done_n;
  logic ovr_n;

  always_comb begin
    done_n = commit | (done & ~rd);
    if (commit & done & ~rd) ovr_n = 1'b1;
    else if (rd)             ovr_n = 1'b0;
    else                     ovr_n = overrun;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      done    <= 1'b0;
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (commit) result <= OUT_W'(code);
      done    <= done_n;
      irq     <= done_n & irq_en;
      overrun <= ovr_n;
    end
  end

  assert_commit_sets_done_R8: assert property (@(posedge clk) disable iff (rst)
    commit |=> done);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && !commit) |=> !done);
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(result));
  assert_commit_value_R4: assert property (@(posedge clk) disable iff (rst)
    commit |=> result == OUT_W'($past(code)));
  assert_irq_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);
  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> ($past(done) && $past(commit)));
endmodule

// File: rtl/adc_result_stage.sv
module adc_result_stage #(
  parameter int RAW_W = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAW_W-1:0] raw_code,
  input  logic             raw_valid,
  input  logic [1:0]       res_sel,
  input  logic             cmp_en,
  input  logic             cmp_above,
  input  logic [RAW_W-1:0] cmp_value,
  input  logic             irq_en,
  input  logic             result_rd,
  output logic [OUT_W-1:0] result,
  output logic             done,
  output logic             irq,
  output logic             overrun
);
  logic [RAW_W-1:0] code_t;
  logic [RAW_W-1:0] thr_t;
  logic             commit;

  rs_trunc #(.RAW_W(RAW_W)) u_trunc_code (
    .mode(res_sel), .code_in(raw_code), .code_out(code_t));

  rs_trunc #(.RAW_W(RAW_W)) u_trunc_thr (
    .mode(res_sel), .code_in(cmp_value), .code_out(thr_t));

  rs_qualify #(.RAW_W(RAW_W)) u_qualify (
    .valid(raw_valid), .cmp_en(cmp_en), .above(cmp_above),
    .code(code_t), .thr(thr_t), .commit(commit));

  rs_hold #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_hold (
    .clk(clk), .rst(rst), .commit(commit), .code(code_t), .rd(result_rd),
    .irq_en(irq_en), .result(result), .done(done), .irq(irq), .overrun(overrun));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    result[OUT_W-1:RAW_W] == '0);
  assert_low_mode_width_R2: assert property (@(posedge clk) disable iff (rst)
    (raw_valid && !cmp_en && res_sel == 2'b00) |=> result[RAW_W-1:RAW_W-4] == '0);
  assert_above_reject_R5: assert property (@(posedge clk) disable iff (rst)
    (raw_valid && cmp_en && cmp_above && code_t <= thr_t && !result_rd)
      |=> ($stable(result) && $stable(done) && $stable(overrun)));
  assert_below_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (raw_valid && cmp_en && !cmp_above && code_t >= thr_t && !result_rd)
      |=> ($stable(result) && $stable(done) && $stable(overrun)));
endmodule

// File: tb/test_adc_result_stage.sv
module test_adc_result_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] raw_code = '0;
  logic        raw_valid = 1'b0;
  logic [1:0]  res_sel = 2'b10;
  logic        cmp_en = 1'b0;
  logic        cmp_above = 1'b0;
  logic [11:0] cmp_value = '0;
  logic        irq_en = 1'b0;
  logic        result_rd = 1'b0;
  logic [15:0] result;
  logic        done, irq, overrun;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  logic [15:0] m_res;
  logic        m_done, m_irq, m_ovr;

  always #4 clk = ~clk;

  adc_result_stage i_adc_result_stage (
    .clk(clk), .rst(rst), .raw_code(raw_code), .raw_valid(raw_valid),
    .res_sel(res_sel), .cmp_en(cmp_en), .cmp_above(cmp_above),
    .cmp_value(cmp_value), .irq_en(irq_en), .result_rd(result_rd),
    .result(result), .done(done), .irq(irq), .overrun(overrun));

  function automatic int width_of(input logic [1:0] m);
    if (m == 2'b00) return 8;
    if (m == 2'b01) return 10;
    return 12;
  endfunction

  // behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_res = 0; m_done = 0; m_irq = 0; m_ovr = 0;
    end else begin
      int w, c, t;
      bit ok;
      w = width_of(res_sel);
      c = int'(raw_code) % (1 << w);
      t = int'(cmp_value) % (1 << w);
      ok = raw_valid && (!cmp_en || (cmp_above ? (c > t) : (c < t)));
      if (ok && m_done && !result_rd) m_ovr = 1;
      else if (result_rd) m_ovr = 0;
      if (ok) begin
        m_res = 16'(c);
        m_done = 1;
      end else if (result_rd) begin
        m_done = 0;
      end
      m_irq = m_done && irq_en;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(tag, "result", result, m_res);
      check(tag, "done", done, m_done);
      check(tag, "irq", irq, m_irq);
      check(tag, "overrun", overrun, m_ovr);
    end
  end

  task automatic pulse(input logic [11:0] r);
    @(negedge clk);
    raw_code = r; raw_valid = 1'b1;
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    result_rd = 1'b1;
    @(negedge clk);
    result_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "reset result", result, 0);
    check("R1", "reset flags", {done, irq, overrun}, 0);

    // R2 8-bit mode
    tag = "R2"; res_sel = 2'b00;
    pulse(12'hABC);
    check("R2", "8-bit result", result, 16'h00BC);
    do_read();
    check("R8", "read clears done", done, 0);

    // R3 10-bit and 12-bit modes
    tag = "R3"; res_sel = 2'b01;
    pulse(12'hABC);
    check("R3", "10-bit result", result, 16'h02BC);
    res_sel = 2'b10; do_read();
    pulse(12'hABC);
    check("R3", "12-bit result", result, 16'h0ABC);
    res_sel = 2'b11; do_read();
    pulse(12'h5A5);
    check("R3", "mode 11 as 12-bit", result, 16'h05A5);
    do_read();

    // R4 back-to-back commits, compare off
    tag = "R4";
    @(negedge clk); raw_valid = 1; raw_code = 12'h111;
    @(negedge clk); raw_code = 12'h222;
    check("R4", "first of stream", result, 16'h0111);
    @(negedge clk); raw_valid = 0;
    check("R4", "second of stream", result, 16'h0222);
    check("R10", "overrun after overwrite", overrun, 1);
    do_read();
    check("R10", "overrun cleared by read", overrun, 0);

    // R5 greater-than filter
    tag = "R5"; res_sel = 2'b10; cmp_en = 1; cmp_above = 1; cmp_value = 12'h800;
    pulse(12'h800);
    check("R5", "equal rejected", done, 0);
    check("R7", "result kept on reject", result, 16'h0222);
    pulse(12'h801);
    check("R5", "above accepted", result, 16'h0801);
    do_read();

    // R6 less-than filter
    tag = "R6"; cmp_above = 0;
    pulse(12'h800);
    check("R6", "equal rejected", done, 0);
    pulse(12'h7FF);
    check("R6", "below accepted", result, 16'h07FF);

    // R7 reject while done set keeps everything
    tag = "R7";
    pulse(12'hFFF);
    check("R7", "done kept", done, 1);
    check("R7", "overrun untouched", overrun, 0);
    do_read();

    // R11 threshold trimmed to resolution
    tag = "R11"; res_sel = 2'b00; cmp_above = 1; cmp_value = 12'h1F0;
    pulse(12'h0F5);
    check("R11", "trimmed threshold compare", result, 16'h00F5);
    do_read();

    // R8 commit together with read keeps done; R9 irq gating
    tag = "R9"; cmp_en = 0; res_sel = 2'b10; irq_en = 1;
    pulse(12'h123);
    check("R9", "irq with done", irq, 1);
    @(negedge clk); raw_valid = 1; raw_code = 12'h456; result_rd = 1;
    @(negedge clk); raw_valid = 0; result_rd = 0;
    check("R8", "commit beats read", done, 1);
    check("R10", "no overrun with read", overrun, 0);
    irq_en = 0;
    @(negedge clk);
    check("R9", "irq masked", irq, 0);
    do_read();

    // randomized mix compared against the model every cycle
    tag = "R4/R5/R6/R7/R8/R9/R10/R11 random";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      raw_code  = 12'($urandom);
      raw_valid = 1'($urandom);
      res_sel   = 2'($urandom);
      cmp_en    = 1'($urandom);
      cmp_above = 1'($urandom);
      cmp_value = 12'($urandom);
      irq_en    = 1'($urandom);
      result_rd = ($urandom % 4) == 0;
    end
    @(negedge clk); raw_valid = 0; result_rd = 0;
    @(negedge clk);
    finish_run();
  end
endmodule